// File: doc/BRIEF.md
# Configurable Fault Response Controller

This block takes digitized fault flags from a motor pre-driver's comparators and decides, per fault class, what happens next. Depending on its mode field, a class reports on an active-low fault pin, latches a status bit, forces the output stage to high impedance, and recovers either after a timed retry or only on an explicit clear. A separate group of regulator faults skips reporting altogether: those faults place the outputs in high impedance and hold the digital core in reset until the condition is gone.

Slow and fast retry delays are parameters given in clock cycles. Each class has its own retry counter. The counter is loaded when the fault is first detected, and the class recovers only after the counter has run out and the flag has dropped. A clear command or a sleep reset pulse releases latched and report-only faults whose condition has already gone. A fault whose condition is still present when the clear arrives stays set.

Top module: `fault_resp_ctrl`

## Requirements
- R1: After reset, `fault_n` is 1 and `status`, `out_hiz`, `drv_dis` and `core_rst` are all 0.
- R2: The overcurrent mode decodes as follows: 000 gives slow retry, 001 gives fast retry, 010 gives latched shutdown, 011 gives report-only with the outputs active, and any value 1xx gives latched shutdown.
- R3: A retry-mode fault loads its class counter with `SLOW_CYC` or `FAST_CYC` on detection. Its status bit and `out_hiz` hold until the counter has expired and the flag is low. Both then clear within three cycles.
- R4: A latched fault keeps its status bit and `out_hiz` until `clr_cmd` or `sleep_rst` pulses while the flag is low. A clear that arrives while the flag is still high has no effect.
- R5: A report-only fault sets its status bit and drives `fault_n` low but leaves `out_hiz` at 0. It clears on a clear pulse once its flag is low.
- R6: The undervoltage-warning mode decodes as follows: 00 gives slow retry, 01 gives fast retry, 10 gives report-only, and 11 gives fully masked (no status bit, no fault pin, no high impedance).
- R7: The serial-interface fault with mode 0 is report-only. With mode 1 it is ignored.
- R8: A configuration parity fault sets `drv_dis`, its status bit and the fault pin without asserting `out_hiz`. It clears only through a clear or sleep pulse after its flag is low.
- R9: Any regulator flag (input undervoltage, undervoltage, over-temperature) asserts `out_hiz` and `core_rst` one cycle later, sets no status bit, leaves `fault_n` high, and releases both one cycle after all regulator flags are low.
- R10: `fault_n` is low exactly when any status bit is set. The status bit positions are: 0 supply undervoltage, 1 undervoltage warning, 2 charge-pump undervoltage, 3 overcurrent, 4 overvoltage, 5 over-temperature warning, 6 over-temperature shutdown, 7 serial-interface fault, 8 parity fault.
- R11: In the two-bit undervoltage, overvoltage and over-temperature mode fields, 00 gives slow retry, 01 gives fast retry, and the reserved values 10 and 11 give latched shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_uv | input | 1 | Supply undervoltage flag |
| flag_uvw | input | 1 | Supply undervoltage warning flag |
| flag_cpuv | input | 1 | Charge-pump undervoltage flag |
| flag_oc | input | 1 | Overcurrent flag |
| flag_ov | input | 1 | Supply overvoltage flag |
| flag_otw | input | 1 | Over-temperature warning flag |
| flag_ots | input | 1 | Over-temperature shutdown flag |
| flag_spi | input | 1 | Serial-interface fault flag |
| flag_par | input | 1 | Configuration parity fault flag |
| flag_reg_in_uv | input | 1 | Regulator input undervoltage flag |
| flag_reg_uv | input | 1 | Regulator undervoltage flag |
| flag_reg_ot | input | 1 | Regulator over-temperature flag |
| mode_uv | input | 2 | Mode for supply and charge-pump undervoltage |
| mode_uvw | input | 2 | Mode for undervoltage warning |
| mode_oc | input | 3 | Mode for overcurrent |
| mode_ov | input | 2 | Mode for overvoltage |
| mode_ot | input | 2 | Mode for over-temperature warning and shutdown |
| mode_spi | input | 1 | Mode for serial-interface fault |
| clr_cmd | input | 1 | Single-cycle fault clear command |
| sleep_rst | input | 1 | Sleep-pin reset pulse, acts as a clear |
| fault_n | output | 1 | Active-low fault pin |
| status | output | 9 | Latched status bits |
| out_hiz | output | 1 | Output stage high-impedance enable |
| drv_dis | output | 1 | Pre-driver disable |
| core_rst | output | 1 | Digital core reset |

## Verification
The bench times retry recovery against both delays. A design that loaded the wrong delay, or that released early while the flag was still high, would drop `out_hiz` at the wrong check point. Clears are issued while the flag is still present, so a design that cleared unconditionally would lose a latched status bit. The reserved encodings and the masked and ignored modes are driven as well: a decoder that fell through to retry would release a latched fault, and one that honoured a masked flag would pull `fault_n` low. Regulator faults are checked for asserting reset and high impedance without ever touching the fault pin or status.

// File: rtl/fault_resp_pkg.sv
package fault_resp_pkg;

  typedef enum logic [2:0] {
    ACT_SLOW   = 3'd0,
    ACT_FAST   = 3'd1,
    ACT_LATCH  = 3'd2,
    ACT_REPORT = 3'd3,
    ACT_MASK   = 3'd4
  } act_e;

  localparam int NUM_CLS = 9;
  localparam int ACT_W   = 3;

  localparam int IDX_UV   = 0;
  localparam int IDX_UVW  = 1;
  localparam int IDX_CPUV = 2;
  localparam int IDX_OC   = 3;
  localparam int IDX_OV   = 4;
  localparam int IDX_OTW  = 5;
  localparam int IDX_OTS  = 6;
  localparam int IDX_SPI  = 7;
  localparam int IDX_PAR  = 8;

  // Two-bit retry field: 00 slow, 01 fast, reserved values latch.
  function automatic act_e dec_retry2(input logic [1:0] m);
    case (m)
      2'b00:   return ACT_SLOW;
      2'b01:   return ACT_FAST;
      default: return ACT_LATCH;
    endcase
  endfunction

endpackage

// File: rtl/fault_mode_decode.sv
module fault_mode_decode
  import fault_resp_pkg::*;
(
  input  logic [1:0]                 mode_uv,
  input  logic [1:0]                 mode_uvw,
  input  logic [2:0]                 mode_oc,
  input  logic [1:0]                 mode_ov,
  input  logic [1:0]                 mode_ot,
  input  logic                       mode_spi,
  output logic [NUM_CLS*ACT_W-1:0]   act_flat
);

  act_e acts [NUM_CLS];

  always_comb begin
    acts[IDX_UV]   = dec_retry2(mode_uv);
    acts[IDX_CPUV] = dec_retry2(mode_uv);
    acts[IDX_OV]   = dec_retry2(mode_ov);
    acts[IDX_OTW]  = dec_retry2(mode_ot);
    acts[IDX_OTS]  = dec_retry2(mode_ot);

    case (mode_uvw)
      2'b00:   acts[IDX_UVW] = ACT_SLOW;
      2'b01:   acts[IDX_UVW] = ACT_FAST;
      2'b10:   acts[IDX_UVW] = ACT_REPORT;
      default: acts[IDX_UVW] = ACT_MASK;
    endcase

    case (mode_oc)
      3'b000:  acts[IDX_OC] = ACT_SLOW;
      3'b001:  acts[IDX_OC] = ACT_FAST;
      3'b011:  acts[IDX_OC] = ACT_REPORT;
      default: acts[IDX_OC] = ACT_LATCH;   // 010 and reserved 1xx
    endcase

    acts[IDX_SPI] = mode_spi ? ACT_MASK : ACT_REPORT;
    acts[IDX_PAR] = ACT_LATCH;
  end

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_flat
    assign act_flat[i*ACT_W +: ACT_W] = acts[i];
  end

endmodule

// File: rtl/fault_class_unit.sv
module fault_class_unit
  import fault_resp_pkg::*;
#(
  parameter int SLOW_CYC = 500000,
  parameter int FAST_CYC = 12500,
  localparam int CNT_W   = $clog2(SLOW_CYC + 1)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_i,
  input  logic [ACT_W-1:0] act_i,
  input  logic             clr_i,
  output logic             status_o,
  output logic             hiz_o
);

  act_e       act;
  logic       is_retry;
  logic [CNT_W-1:0] cnt_q;
  logic       stat_q;

  assign act      = act_e'(act_i);
  assign is_retry = (act == ACT_SLOW) || (act == ACT_FAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      cnt_q  <= '0;
    end else if (act == ACT_MASK) begin
      stat_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!stat_q) begin
      if (flag_i) begin
        stat_q <= 1'b1;
        if (act == ACT_SLOW)      cnt_q <= CNT_W'(SLOW_CYC);
        else if (act == ACT_FAST) cnt_q <= CNT_W'(FAST_CYC);
        else                      cnt_q <= '0;
      end
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (is_retry) begin
        if (cnt_q == '0 && !flag_i) stat_q <= 1'b0;
      end else if (clr_i && !flag_i) begin
        stat_q <= 1'b0;
      end
    end
  end

  assign status_o = stat_q;
  assign hiz_o    = stat_q && (is_retry || act == ACT_LATCH);

  p_mask_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_MASK) |=> !stat_q);

  p_retry_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_q && is_retry && cnt_q != '0) |=> stat_q);

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !is_retry && act != ACT_MASK && !clr_i) |=> stat_q);

  p_flag_sets_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_i && act != ACT_MASK) |=> stat_q);

endmodule

// File: rtl/fault_resp_ctrl.sv
module fault_resp_ctrl
  import fault_resp_pkg::*;
#(
  parameter int SLOW_CYC = 500000,
  parameter int FAST_CYC = 12500
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               flag_uv,
  input  logic               flag_uvw,
  input  logic               flag_cpuv,
  input  logic               flag_oc,
  input  logic               flag_ov,
  input  logic               flag_otw,
  input  logic               flag_ots,
  input  logic               flag_spi,
  input  logic               flag_par,
  input  logic               flag_reg_in_uv,
  input  logic               flag_reg_uv,
  input  logic               flag_reg_ot,
  input  logic [1:0]         mode_uv,
  input  logic [1:0]         mode_uvw,
  input  logic [2:0]         mode_oc,
  input  logic [1:0]         mode_ov,
  input  logic [1:0]         mode_ot,
  input  logic               mode_spi,
  input  logic               clr_cmd,
  input  logic               sleep_rst,
  output logic               fault_n,
  output logic [NUM_CLS-1:0] status,
  output logic               out_hiz,
  output logic               drv_dis,
  output logic               core_rst
);

  localparam logic [NUM_CLS-1:0] HIZ_SEL = ~(NUM_CLS'(1) << IDX_PAR);

  logic [NUM_CLS-1:0]       flags;
  logic [NUM_CLS-1:0]       stat;
  logic [NUM_CLS-1:0]       hz;
  logic [NUM_CLS*ACT_W-1:0] act_flat;
  logic                     clr_any;
  logic                     reg_flt;

  assign flags = {flag_par, flag_spi, flag_ots, flag_otw, flag_ov,
                  flag_oc, flag_cpuv, flag_uvw, flag_uv};
  assign clr_any = clr_cmd | sleep_rst;
  assign reg_flt = flag_reg_in_uv | flag_reg_uv | flag_reg_ot;

  fault_mode_decode u_dec (
    .mode_uv  (mode_uv),
    .mode_uvw (mode_uvw),
    .mode_oc  (mode_oc),
    .mode_ov  (mode_ov),
    .mode_ot  (mode_ot),
    .mode_spi (mode_spi),
    .act_flat (act_flat)
  );

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
    fault_class_unit #(
      .SLOW_CYC (SLOW_CYC),
      .FAST_CYC (FAST_CYC)
    ) u_cls (
      .clk      (clk),
      .rst      (rst),
      .flag_i   (flags[i]),
      .act_i    (act_flat[i*ACT_W +: ACT_W]),
      .clr_i    (clr_any),
      .status_o (stat[i]),
      .hiz_o    (hz[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_n  <= 1'b1;
      status   <= '0;
      out_hiz  <= 1'b0;
      drv_dis  <= 1'b0;
      core_rst <= 1'b0;
    end else begin
      fault_n  <= ~|stat;
      status   <= stat;
      out_hiz  <= (|(hz & HIZ_SEL)) | reg_flt;
      drv_dis  <= stat[IDX_PAR];
      core_rst <= reg_flt;
    end
  end

  p_core_rst_r9: assert property (@(posedge clk) disable iff (rst)
    reg_flt |=> (core_rst && out_hiz));

  p_par_dis_r8: assert property (@(posedge clk) disable iff (rst)
    flag_par |=> ##1 drv_dis);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (fault_n && status == '0 && !out_hiz && !core_rst));

endmodule

// File: tb/fault_resp_ctrl_tb_top.sv
module fault_resp_ctrl_tb_top;

  localparam int SLOW = 40;
  localparam int FAST = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flag_uv = 0, flag_uvw = 0, flag_cpuv = 0, flag_oc = 0, flag_ov = 0;
  logic flag_otw = 0, flag_ots = 0, flag_spi = 0, flag_par = 0;
  logic flag_reg_in_uv = 0, flag_reg_uv = 0, flag_reg_ot = 0;
  logic [1:0] mode_uv = 0, mode_uvw = 0, mode_ov = 0, mode_ot = 0;
  logic [2:0] mode_oc = 0;
  logic mode_spi = 0, clr_cmd = 0, sleep_rst = 0;
  logic fault_n, out_hiz, drv_dis, core_rst;
  logic [8:0] status;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fault_resp_ctrl #(.SLOW_CYC(SLOW), .FAST_CYC(FAST)) dut_i (
    .clk(clk), .rst(rst),
    .flag_uv(flag_uv), .flag_uvw(flag_uvw), .flag_cpuv(flag_cpuv),
    .flag_oc(flag_oc), .flag_ov(flag_ov), .flag_otw(flag_otw),
    .flag_ots(flag_ots), .flag_spi(flag_spi), .flag_par(flag_par),
    .flag_reg_in_uv(flag_reg_in_uv), .flag_reg_uv(flag_reg_uv),
    .flag_reg_ot(flag_reg_ot),
    .mode_uv(mode_uv), .mode_uvw(mode_uvw), .mode_oc(mode_oc),
    .mode_ov(mode_ov), .mode_ot(mode_ot), .mode_spi(mode_spi),
    .clr_cmd(clr_cmd), .sleep_rst(sleep_rst),
    .fault_n(fault_n), .status(status), .out_hiz(out_hiz),
    .drv_dis(drv_dis), .core_rst(core_rst)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_clr(input bit use_sleep);
    if (use_sleep) sleep_rst = 1; else clr_cmd = 1;
    step(1);
    sleep_rst = 0; clr_cmd = 0;
    step(2);
  endtask

  task automatic t_reset;
    chk("R1", "fault_n", fault_n, 1);
    chk("R1", "status", status, 0);
    chk("R1", "out_hiz", out_hiz, 0);
    chk("R1", "drv_dis", drv_dis, 0);
    chk("R1", "core_rst", core_rst, 0);
  endtask

  task automatic t_oc_fast;
    mode_oc = 3'b001;
    flag_oc = 1; step(1); flag_oc = 0;
    step(FAST - 1);
    chk("R2", "oc fast hiz before expiry", out_hiz, 1);
    chk("R3", "oc fast status before expiry", status[3], 1);
    step(4);
    chk("R3", "oc fast hiz after expiry", out_hiz, 0);
    chk("R2", "oc fast pin after expiry", fault_n, 1);
  endtask

  task automatic t_oc_slow;
    mode_oc = 3'b000;
    flag_oc = 1; step(1); flag_oc = 0;
    step(FAST + 3);
    chk("R2", "oc slow still hiz at fast time", out_hiz, 1);
    step(SLOW);
    chk("R3", "oc slow hiz after expiry", out_hiz, 0);
  endtask

  task automatic t_retry_flag_held;
    mode_ov = 2'b01;
    flag_ov = 1; step(3 * FAST);
    chk("R3", "ov held past timer keeps hiz", out_hiz, 1);
    chk("R3", "ov held status", status[4], 1);
    flag_ov = 0; step(3);
    chk("R3", "ov released hiz", out_hiz, 0);
    chk("R3", "ov released status", status[4], 0);
  endtask

  task automatic t_oc_latch;
    mode_oc = 3'b010;
    flag_oc = 1; step(1);
    pulse_clr(0);
    chk("R4", "clear while flag high keeps status", status[3], 1);
    flag_oc = 0; step(SLOW + 5);
    chk("R4", "latched hiz after long wait", out_hiz, 1);
    chk("R2", "latched pin", fault_n, 0);
    pulse_clr(0);
    chk("R4", "latched cleared by clear", status[3], 0);
    chk("R4", "latched hiz released", out_hiz, 0);
  endtask

  task automatic t_oc_reserved;
    mode_oc = 3'b101;
    flag_oc = 1; step(1); flag_oc = 0;
    step(SLOW + 5);
    chk("R2", "reserved 1xx latches", out_hiz, 1);
    pulse_clr(1);
    chk("R4", "sleep pulse clears latch", status[3], 0);
  endtask

  task automatic t_oc_report;
    mode_oc = 3'b011;
    flag_oc = 1; step(1); flag_oc = 0; step(2);
    chk("R5", "report status", status[3], 1);
    chk("R5", "report pin", fault_n, 0);
    chk("R5", "report no hiz", out_hiz, 0);
    step(SLOW + 5);
    chk("R5", "report stays set", status[3], 1);
    pulse_clr(0);
    chk("R5", "report cleared", status[3], 0);
    chk("R10", "pin released", fault_n, 1);
  endtask

  task automatic t_uvw;
    mode_uvw = 2'b11;
    flag_uvw = 1; step(3);
    chk("R6", "masked status", status[1], 0);
    chk("R6", "masked pin", fault_n, 1);
    chk("R6", "masked hiz", out_hiz, 0);
    flag_uvw = 0; mode_uvw = 2'b10;
    flag_uvw = 1; step(1); flag_uvw = 0; step(2);
    chk("R6", "report status", status[1], 1);
    chk("R6", "report no hiz", out_hiz, 0);
    pulse_clr(0);
    mode_uvw = 2'b00;
    flag_uvw = 1; step(1); flag_uvw = 0;
    step(FAST + 3);
    chk("R6", "slow retry hiz", out_hiz, 1);
    step(SLOW);
    chk("R6", "slow retry released", status[1], 0);
    mode_uvw = 2'b01;
    flag_uvw = 1; step(1); flag_uvw = 0;
    step(FAST + 3);
    chk("R6", "fast retry released", out_hiz, 0);
  endtask

  task automatic t_spi;
    mode_spi = 1;
    flag_spi = 1; step(3); flag_spi = 0;
    chk("R7", "ignored spi status", status[7], 0);
    chk("R7", "ignored spi pin", fault_n, 1);
    mode_spi = 0;
    flag_spi = 1; flag_oc = 1; mode_oc = 3'b011;
    step(1); flag_spi = 0; flag_oc = 0; step(2);
    chk("R7", "spi report status", status[7], 1);
    chk("R7", "spi keeps outputs active", out_hiz, 0);
    chk("R10", "two status bits", status, 9'h088);
    pulse_clr(0);
    chk("R10", "both cleared pin", fault_n, 1);
  endtask

  task automatic t_par;
    flag_par = 1; step(3);
    chk("R8", "parity drv_dis", drv_dis, 1);
    chk("R8", "parity pin", fault_n, 0);
    chk("R8", "parity no hiz", out_hiz, 0);
    pulse_clr(0);
    chk("R8", "parity held under clear", status[8], 1);
    flag_par = 0; step(SLOW + 5);
    chk("R8", "parity still latched", drv_dis, 1);
    pulse_clr(1);
    chk("R8", "parity cleared", drv_dis, 0);
  endtask

  task automatic t_reg(input int which);
    flag_reg_in_uv = (which == 0);
    flag_reg_uv    = (which == 1);
    flag_reg_ot    = (which == 2);
    step(2);
    chk("R9", "core_rst asserted", core_rst, 1);
    chk("R9", "hiz asserted", out_hiz, 1);
    chk("R9", "no pin", fault_n, 1);
    chk("R9", "no status", status, 0);
    flag_reg_in_uv = 0; flag_reg_uv = 0; flag_reg_ot = 0;
    step(2);
    chk("R9", "core_rst released", core_rst, 0);
    chk("R9", "hiz released", out_hiz, 0);
  endtask

  task automatic t_reserved2;
    mode_uv = 2'b10;
    flag_cpuv = 1; step(1); flag_cpuv = 0;
    step(SLOW + 5);
    chk("R11", "cp uv reserved latches", status[2], 1);
    pulse_clr(0);
    chk("R11", "cp uv cleared", status[2], 0);
    mode_ot = 2'b11;
    flag_ots = 1; step(1); flag_ots = 0;
    step(SLOW + 5);
    chk("R11", "ots reserved latches", out_hiz, 1);
    pulse_clr(0);
    mode_uv = 2'b01;
    flag_uv = 1; step(1); flag_uv = 0;
    step(FAST + 3);
    chk("R11", "uv fast released", status[0], 0);
  endtask

  initial begin
    fork
      begin
        step(100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        step(4);
        rst = 0;
        step(1);
        t_reset();
        t_oc_fast();
        t_oc_slow();
        t_retry_flag_held();
        t_oc_latch();
        t_oc_reserved();
        t_oc_report();
        t_uvw();
        t_spi();
        t_par();
        for (int k = 0; k < 3; k++) t_reg(k);
        t_reserved2();
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule